// File: doc/BRIEF.md
# Fractional-Increment System Time Counter

This block keeps a free-running 64-bit fixed-point time value. A reference tick strobe, synchronous to the block clock, tells it when to advance. On each tick the time grows by a programmable increment word rather than by one. Software can trim the effective frequency in fine steps by rewriting that word while the counter runs. Other timing logic can then derive nanoseconds with a fixed right shift. For example, with a 6.4 ns tick a word of 0x66666666 pairs with a shift of 28. The word 0x40000000 with shift 24 suits a 64 ns tick, and 0x50000000 with shift 21 suits a 640 ns tick. That shift is applied outside the block.

A small register port, built as a valid/ready request channel and a valid/ready response channel, gives access to three things: the increment word, the low time word and the high time word. A parameter selects one of two increment formats. The wide format has a 31-bit increment field. The narrow format has a 24-bit increment field plus an enable bit for the increment period at bit 24, which must be 1 for the counter to run. In the narrow format, both the nominal increment and the shift are 7 bits smaller. The full time value is also driven out in parallel, together with a one-cycle flag that marks a wrap past 2^64.

Top module: `sysclk_time`

## Requirements
- R1: After reset the time output is 0, the wrap flag is 0, no response is pending, req_ready is 1 and the increment word reads back as 0.
- R2: In a cycle where tick is 1, the time output shows old time plus the effective increment on the following cycle, modulo 2^64. Without a tick, the time holds.
- R3: When the effective increment is zero, the time output does not change on ticks.
- R4: Wide format (NARROW=0): write data bits [30:0] form the increment. Bit 31 is dropped and reads back as 0.
- R5: Narrow format (NARROW=1): bits [23:0] form the increment and bit 24 is the period-enable bit. If bit 24 is 0, the effective increment is zero. Bits [31:25] are dropped and read back as 0.
- R6: A write to the increment word (address 2) leaves the time unchanged. The new word applies from the next tick after the write is accepted.
- R7: A write to address 0 only stages the low word. A write to address 1 loads {write data, staged low} into the time on the next cycle, and this takes priority over a tick in the same cycle. Writing 0 to both words restarts the time from 0.
- R8: A read of address 0 returns the low time word and copies the high word into a shadow. A read of address 1 returns that shadow, not the live high word.
- R9: Read data appears with rsp_valid one cycle after the request is accepted. While rsp_valid is 1 and rsp_ready is 0, rsp_valid and rsp_rdata hold steady. While a response is pending, req_ready is 0.
- R10: When a tick carries the time past 2^64-1, wrap_o is 1 for exactly the cycle in which the wrapped time first shows.
- R11: Address 3 is unused. Writes to it change nothing and reads from it return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Reference tick strobe, one cycle wide per tick |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready; 0 while a read response is pending |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 2 | 0 time low, 1 time high, 2 increment, 3 unused |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_rdata | output | 32 | Read response data |
| time_o | output | 64 | Current time value |
| wrap_o | output | 1 | One-cycle wrap flag |

## Verification
Each tick, and each load of the high word, shows on time_o one cycle after the clock edge that captured it. wrap_o appears in that same cycle. An increment write changes nothing at the time it is taken and first affects the next tick. Read data arrives one cycle after acceptance and then waits for rsp_ready. The bench drives inputs on falling edges and runs a behavioural model on rising edges. It compares every output on the next falling edge, so each result is checked in exactly the cycle it is due. Directed checks with hand-computed values are added at the corner cases.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  typedef enum logic [1:0] {
    SEL_TLO  = 2'd0,
    SEL_THI  = 2'd1,
    SEL_INC  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam int unsigned WIDE_FIELD_W   = 31;
  localparam int unsigned NARROW_FIELD_W = 24;

endpackage

// File: rtl/sysclk_inc_reg.sv
module sysclk_inc_reg
  import sysclk_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter bit          NARROW = 1'b0,
  localparam int unsigned IN_W  = NARROW ? (NARROW_FIELD_W + 1) : WIDE_FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IN_W-1:0]   wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] inc_eff
);

  logic [IN_W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (wr_en) begin
      store_q <= wr_data;
    end
  end

  assign rd_data = {{(DATA_W-IN_W){1'b0}}, store_q};

  generate
    if (NARROW) begin : g_narrow
      // top bit of the stored field is the period enable
      logic period_on;
      assign period_on = store_q[NARROW_FIELD_W];
      assign inc_eff = period_on
                     ? {{(DATA_W-NARROW_FIELD_W){1'b0}}, store_q[NARROW_FIELD_W-1:0]}
                     : '0;
    end else begin : g_wide
      assign inc_eff = {{(DATA_W-IN_W){1'b0}}, store_q};
    end
  endgenerate

endmodule

// File: rtl/sysclk_accum.sv
module sysclk_accum #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned INC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [INC_W-1:0]  inc,
  input  logic              load_en,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] time_q,
  output logic              wrap_q
);

  localparam int unsigned PAD_W = TIME_W - INC_W + 1;

  logic [TIME_W:0] sum;

  assign sum = {1'b0, time_q} + {{PAD_W{1'b0}}, inc};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q <= '0;
      wrap_q <= 1'b0;
    end else if (load_en) begin
      time_q <= load_val;
      wrap_q <= 1'b0;
    end else if (tick) begin
      time_q <= sum[TIME_W-1:0];
      wrap_q <= sum[TIME_W];
    end else begin
      wrap_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sysclk_regif.sv
module sysclk_regif
  import sysclk_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned TIME_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [TIME_W-1:0] time_q,
  input  logic [DATA_W-1:0] inc_rd,
  output logic              inc_wr_en,
  output logic              load_en,
  output logic [TIME_W-1:0] load_val
);

  sel_e              sel;
  logic              accept;
  logic              rd_take;
  logic              wr_take;
  logic [DATA_W-1:0] lo_stage_q;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] rd_mux;

  assign sel       = sel_e'(req_addr);
  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign rd_take   = accept && !req_write;
  assign wr_take   = accept && req_write;

  assign inc_wr_en = wr_take && (sel == SEL_INC);
  assign load_en   = wr_take && (sel == SEL_THI);
  assign load_val  = {req_wdata, lo_stage_q};

  always_comb begin
    case (sel)
      SEL_TLO: rd_mux = time_q[DATA_W-1:0];
      SEL_THI: rd_mux = shadow_q;
      SEL_INC: rd_mux = inc_rd;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      lo_stage_q <= '0;
      shadow_q   <= '0;
    end else begin
      if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (rd_take) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_mux;
        if (sel == SEL_TLO) begin
          shadow_q <= time_q[TIME_W-1:DATA_W];
        end
      end
      if (wr_take && (sel == SEL_TLO)) begin
        lo_stage_q <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/sysclk_time.sv
module sysclk_time
  import sysclk_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter bit          NARROW = 1'b0,
  localparam int unsigned TIME_W = 2 * DATA_W,
  localparam int unsigned IN_W   = NARROW ? (NARROW_FIELD_W + 1) : WIDE_FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [TIME_W-1:0] time_o,
  output logic              wrap_o
);

  logic              inc_wr_en;
  logic [DATA_W-1:0] inc_rd;
  logic [DATA_W-1:0] inc_eff;
  logic              load_en;
  logic [TIME_W-1:0] load_val;

  sysclk_regif #(.DATA_W(DATA_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .time_q    (time_o),
    .inc_rd    (inc_rd),
    .inc_wr_en (inc_wr_en),
    .load_en   (load_en),
    .load_val  (load_val)
  );

  sysclk_inc_reg #(.DATA_W(DATA_W), .NARROW(NARROW)) u_inc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (inc_wr_en),
    .wr_data (req_wdata[IN_W-1:0]),
    .rd_data (inc_rd),
    .inc_eff (inc_eff)
  );

  sysclk_accum #(.TIME_W(TIME_W), .INC_W(DATA_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .inc      (inc_eff),
    .load_en  (load_en),
    .load_val (load_val),
    .time_q   (time_o),
    .wrap_q   (wrap_o)
  );

endmodule

// File: rtl/sysclk_time_chk.sv
module sysclk_time_chk
  import sysclk_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TIME_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [TIME_W-1:0] time_o,
  input logic              wrap_o,
  input logic [DATA_W-1:0] inc_eff
);

  logic load;
  assign load = req_valid && req_ready && req_write && (req_addr == SEL_THI);

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(time_o));

  p_tick_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (time_o == ($past(time_o) + {{(TIME_W-DATA_W){1'b0}}, $past(inc_eff)})));

  p_zero_inc_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((inc_eff == '0) && !load) |=> $stable(time_o));

  p_load_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (time_o[TIME_W-1:DATA_W] == $past(req_wdata)));

  p_read_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_wrap_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> !wrap_o);

  p_wrap_small_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> (time_o[TIME_W-1:DATA_W-1] == '0));

endmodule

bind sysclk_time sysclk_time_chk #(.DATA_W(DATA_W), .TIME_W(TIME_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .time_o    (time_o),
  .wrap_o    (wrap_o),
  .inc_eff   (inc_eff)
);

// File: tb/tb_sysclk_time.sv
module tb_sysclk_time;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = 2'd0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [63:0] time_o;
  logic        wrap_o;

  logic        n_req_valid = 1'b0;
  logic        n_req_ready;
  logic        n_req_write = 1'b0;
  logic [1:0]  n_req_addr = 2'd0;
  logic [31:0] n_req_wdata = '0;
  logic        n_rsp_valid;
  logic [31:0] n_rsp_rdata;
  logic [63:0] n_time_o;
  logic        n_wrap_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysclk_time #(.DATA_W(32), .NARROW(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .time_o(time_o), .wrap_o(wrap_o)
  );

  sysclk_time #(.DATA_W(32), .NARROW(1'b1)) dut_n (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(n_req_valid), .req_ready(n_req_ready), .req_write(n_req_write),
    .req_addr(n_req_addr), .req_wdata(n_req_wdata),
    .rsp_valid(n_rsp_valid), .rsp_ready(1'b1), .rsp_rdata(n_rsp_rdata),
    .time_o(n_time_o), .wrap_o(n_wrap_o)
  );

  // behavioural reference for the wide instance
  logic [63:0] m_time;
  logic        m_wrap;
  logic [30:0] m_inc;
  logic [31:0] m_stage;
  logic [31:0] m_shadow;
  logic        m_rsp_valid;
  logic [31:0] m_rsp_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_time = '0; m_wrap = 1'b0; m_inc = '0; m_stage = '0;
      m_shadow = '0; m_rsp_valid = 1'b0; m_rsp_data = '0;
    end else begin
      bit acc;
      logic [64:0] nxt;
      logic [30:0] old_inc;
      acc = req_valid && !m_rsp_valid;
      old_inc = m_inc;
      if (m_rsp_valid && rsp_ready) m_rsp_valid = 1'b0;
      if (acc && req_write && req_addr == 2'd1) begin
        m_time = {req_wdata, m_stage};
        m_wrap = 1'b0;
      end else if (tick) begin
        nxt = {1'b0, m_time} + {34'd0, old_inc};
        m_time = nxt[63:0];
        m_wrap = nxt[64];
      end else begin
        m_wrap = 1'b0;
      end
      if (acc && !req_write) begin
        m_rsp_valid = 1'b1;
        case (req_addr)
          2'd0: begin m_rsp_data = m_time_prev_lo; m_shadow = m_time_prev_hi; end
          2'd1: m_rsp_data = m_shadow;
          2'd2: m_rsp_data = {1'b0, old_inc};
          default: m_rsp_data = '0;
        endcase
      end
      if (acc && req_write && req_addr == 2'd0) m_stage = req_wdata;
      if (acc && req_write && req_addr == 2'd2) m_inc = req_wdata[30:0];
    end
  end

  // time as it stood before the current edge, for read data
  logic [31:0] m_time_prev_lo;
  logic [31:0] m_time_prev_hi;
  always @(negedge clk) begin
    m_time_prev_lo = m_time[31:0];
    m_time_prev_hi = m_time[63:32];
  end

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check64("R2 model time", time_o, m_time);
      check64("R10 model wrap", {63'd0, wrap_o}, {63'd0, m_wrap});
      check64("R9 model rsp_valid", {63'd0, rsp_valid}, {63'd0, m_rsp_valid});
      check64("R9 model req_ready", {63'd0, req_ready}, {63'd0, !m_rsp_valid});
      if (m_rsp_valid) check64("R8 model rdata", {32'd0, rsp_rdata}, {32'd0, m_rsp_data});
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic n_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    n_req_valid = 1'b1; n_req_write = 1'b1; n_req_addr = a; n_req_wdata = d;
    while (!n_req_ready) @(negedge clk);
    @(negedge clk);
    n_req_valid = 1'b0; n_req_write = 1'b0;
  endtask

  task automatic n_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    n_req_valid = 1'b1; n_req_write = 1'b0; n_req_addr = a;
    while (!n_req_ready) @(negedge clk);
    @(negedge clk);
    n_req_valid = 1'b0;
    d = n_rsp_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      report();
    end
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] snap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check64("R1 time after reset", time_o, 64'd0);
    check64("R1 wrap after reset", {63'd0, wrap_o}, 64'd0);
    check64("R1 no response pending", {63'd0, rsp_valid}, 64'd0);
    check64("R1 req_ready after reset", {63'd0, req_ready}, 64'd1);
    bus_read(2'd2, rd);
    check64("R1 increment reads zero", {32'd0, rd}, 64'd0);

    // R3 zero increment freezes
    ticks(3);
    check64("R3 frozen on zero increment", time_o, 64'd0);

    // R6 increment write does not move time; R4 wide read back
    bus_write(2'd2, 32'h6666_6666);
    check64("R6 time untouched by increment write", time_o, 64'd0);
    bus_read(2'd2, rd);
    check64("R4 wide increment readback", {32'd0, rd}, 64'h6666_6666);

    // R2 advance
    ticks(4);
    check64("R2 four ticks", time_o, 64'h1_9999_9998);

    // R4 bit 31 dropped
    bus_write(2'd2, 32'hE666_6666);
    bus_read(2'd2, rd);
    check64("R4 bit31 dropped", {32'd0, rd}, 64'h6666_6666);

    // R8 shadowed high word
    bus_read(2'd0, rd);
    check64("R8 low word read", {32'd0, rd}, 64'h9999_9998);
    ticks(2);
    check64("R2 two more ticks", time_o, 64'h2_6666_6664);
    bus_read(2'd1, rd);
    check64("R8 high read returns shadow", {32'd0, rd}, 64'd1);

    // R9 back-pressure on response
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    tick = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check64("R9 rsp held valid", {63'd0, rsp_valid}, 64'd1);
      check64("R9 rsp data held", {32'd0, rsp_rdata}, 64'h6666_6664);
      check64("R9 req stalled", {63'd0, req_ready}, 64'd0);
    end
    tick = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check64("R9 response retired", {63'd0, rsp_valid}, 64'd0);

    // R11 unused address
    snap = time_o;
    bus_write(2'd3, 32'h1234_5678);
    check64("R11 time unchanged by addr3 write", time_o, snap);
    bus_read(2'd2, rd);
    check64("R11 increment unchanged by addr3 write", {32'd0, rd}, 64'h6666_6666);
    bus_read(2'd3, rd);
    check64("R11 addr3 reads zero", {32'd0, rd}, 64'd0);

    // R7 staged load with a tick in the same cycle
    snap = time_o;
    bus_write(2'd0, 32'hFFFF_FFF0);
    check64("R7 low write only stages", time_o, snap);
    @(negedge clk);
    tick = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 2'd1; req_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    tick = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    check64("R7 load wins over tick", time_o, 64'hFFFF_FFFF_FFFF_FFF0);

    // R10 wrap
    bus_write(2'd2, 32'h0000_0020);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check64("R10 wrapped time", time_o, 64'h10);
    check64("R10 wrap flag raised", {63'd0, wrap_o}, 64'd1);
    @(negedge clk);
    check64("R10 wrap flag one cycle", {63'd0, wrap_o}, 64'd0);

    // R7 restart from zero
    bus_write(2'd0, 32'd0);
    bus_write(2'd1, 32'd0);
    check64("R7 zero restart", time_o, 64'd0);
    ticks(1);
    check64("R2 after restart", time_o, 64'h20);

    // R5 narrow format instance
    n_write(2'd2, 32'h0100_0080);
    ticks(3);
    check64("R5 narrow run", n_time_o, 64'h180);
    n_write(2'd2, 32'h0000_0080);
    ticks(2);
    check64("R5 narrow period bit clear freezes", n_time_o, 64'h180);
    n_write(2'd2, 32'hFF00_0080);
    n_read(2'd2, rd);
    check64("R5 narrow readback drops high bits", {32'd0, rd}, 64'h0100_0080);
    ticks(1);
    check64("R5 narrow resumes", n_time_o, 64'h200);

    repeat (2) @(negedge clk);
    done = 1'b1;
    report();
  end

endmodule